// File: doc/BRIEF.md
# Latched 64-bit Free-Running Counter

This block is a 64-bit up-counter that software reaches through a small register bus of 32-bit words. The counter never stops and wraps past its top value. It advances either on every clock or once per programmable number of clocks.

Reading a 64-bit value as two 32-bit words risks a carry between the two reads. To avoid this, software issues a snapshot command. The command copies the whole count into a pair of held registers in one cycle. Software can then read those two words at leisure.

The same command field can instead preload the counter from a pair of load words. A preload always places both halves at once. The bus is a plain address / write-enable / write-data port with a combinational read-data return.

Top module: `snap_counter64`

## Requirements
- R1: After reset, the control word, both load words and both snapshot words read zero. The counter starts from zero.
- R2: With a divider of zero, the count rises by one on every clock. A carry out of the low word shows up in the high word on the same clock.
- R3: The divider sits in control bits [15:8]. A value of N makes the count rise once every N+1 clocks.
- R4: Writing control with bit 0 = 1 and bit 1 = 0 takes a snapshot. Both snapshot words receive the count as it stood in the cycle of the write.
- R5: The snapshot words keep their value until the next snapshot command, even while the counter runs.
- R6: Writing control with bit 0 = 1 and bit 1 = 1 loads the counter from the two load words. The loaded value reads back on the next clock. The load wins over counting, and the divider phase restarts from zero.
- R7: The count wraps from all ones to zero and keeps running.
- R8: Control bits 0 and 1 always read as zero. A control read returns the divider in bits [15:8].
- R9: Writes to the live count words or the snapshot words change nothing. A control write with bit 0 = 0 neither loads nor snapshots.
- R10: The byte address map is: control 0x00, live count low/high 0x04/0x08, load low/high 0x0C/0x10, snapshot low/high 0x14/0x18. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
A wrong prescaler phase or a missed increment shows on the live count words at the very next read. From then on the offset to the expected count grows. A snapshot taken from the wrong cycle, or a snapshot word that drifts, shows as a mismatch on the first read of the snapshot words. That read can come many cycles after the command, so the bench reads them both at once and after long idle gaps. A load that is applied a cycle late, or that lets counting win, shows as a one-count error on the first live read after the load. Carry and wrap faults appear only at the word and range boundaries, so the bench preloads values just below those boundaries.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int unsigned REG_STRIDE = 4;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_LIVE = 8'h04;
  localparam logic [7:0] OFS_LOAD = 8'h0C;
  localparam logic [7:0] OFS_SNAP = 8'h14;

  localparam int unsigned CMD_GO_BIT   = 0;
  localparam int unsigned CMD_LOAD_BIT = 1;
  localparam int unsigned DIV_LSB      = 8;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LATCH = 2'd1,
    CMD_LOAD  = 2'd2
  } cmd_e;
endpackage

// File: rtl/snapcnt_prescale.sv
module snapcnt_prescale #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap_w;

  // >= keeps the phase sane when the divider shrinks mid-period
  assign wrap_w = (pre_q >= div_i);
  assign tick_o = wrap_w && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (wrap_w)    pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  // R3: with a nonzero divider, two ticks never come back to back
  a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/snapcnt_core.sv
module snapcnt_core #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r6_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R2, R7: plain increment, wrapping at full width
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [DIV_W-1:0]  div_o
);
  localparam int unsigned NW = CNT_W / DATA_W;

  logic [NW-1:0][DATA_W-1:0] load_q;
  logic [NW-1:0][DATA_W-1:0] snap_q;
  logic [DIV_W-1:0]          div_q;
  logic                      ctrl_hit;
  cmd_e                      cmd;

  assign ctrl_hit = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));

  always_comb begin
    cmd = CMD_NONE;
    if (ctrl_hit && wdata_i[CMD_GO_BIT])
      cmd = wdata_i[CMD_LOAD_BIT] ? CMD_LOAD : CMD_LATCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (ctrl_hit) div_q <= wdata_i[DIV_LSB +: DIV_W];
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    localparam logic [ADDR_W-1:0] LOAD_ADDR = ADDR_W'(OFS_LOAD + REG_STRIDE * i);
    logic load_hit;
    assign load_hit = wr_en_i && (addr_i == LOAD_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       load_q[i] <= '0;
      else if (load_hit) load_q[i] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                snap_q[i] <= '0;
      else if (cmd == CMD_LATCH)  snap_q[i] <= cnt_i[i*DATA_W +: DATA_W];
    end

    assign load_val_o[i*DATA_W +: DATA_W] = load_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) rdata_o[DIV_LSB +: DIV_W] = div_q;
    for (int i = 0; i < NW; i++) begin
      if (addr_i == ADDR_W'(OFS_LIVE + REG_STRIDE * i)) rdata_o = cnt_i[i*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(OFS_LOAD + REG_STRIDE * i)) rdata_o = load_q[i];
      if (addr_i == ADDR_W'(OFS_SNAP + REG_STRIDE * i)) rdata_o = snap_q[i];
    end
  end

  assign load_o = (cmd == CMD_LOAD);
  assign div_o  = div_q;

  a_r4_snap_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_LATCH) |=> (snap_q == $past(cnt_i)));

  a_r5_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_LATCH) |=> $stable(snap_q));

  a_r8_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_CTRL)) |-> (rdata_o[CMD_LOAD_BIT:CMD_GO_BIT] == '0));
endmodule

// File: rtl/snap_counter64.sv
module snap_counter64
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] load_val_w;
  logic [DIV_W-1:0] div_w;
  logic             load_w;
  logic             tick_w;

  snapcnt_regs #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .DIV_W (DIV_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .cnt_i     (cnt_w),
    .load_o    (load_w),
    .load_val_o(load_val_w),
    .div_o     (div_w)
  );

  snapcnt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_w),
    .restart_i(load_w),
    .tick_o   (tick_w)
  );

  snapcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .load_i    (load_w),
    .load_val_i(load_val_w),
    .cnt_o     (cnt_w)
  );
endmodule

// File: tb/sim_snap_counter64.sv
`timescale 1ns/1ps
module sim_snap_counter64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  snap_counter64 u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .wr_en_i(wr_en),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  // reference model built from the requirements
  logic [63:0] m_cnt, m_snap;
  logic [31:0] m_ld_lo, m_ld_hi;
  logic [7:0]  m_div, m_pre;
  logic        c_w, go, ld, lt;
  assign c_w = wr_en && addr == 8'h00;
  assign go  = c_w && wdata[0];
  assign ld  = go && wdata[1];
  assign lt  = go && !wdata[1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_snap <= '0; m_ld_lo <= '0; m_ld_hi <= '0; m_div <= '0; m_pre <= '0;
    end else begin
      if (lt) m_snap <= m_cnt;
      if (ld) begin m_cnt <= {m_ld_hi, m_ld_lo}; m_pre <= '0; end
      else if (m_pre >= m_div) begin m_cnt <= m_cnt + 64'd1; m_pre <= '0; end
      else m_pre <= m_pre + 8'd1;
      if (c_w) m_div <= wdata[15:8];
      if (wr_en && addr == 8'h0C) m_ld_lo <= wdata;
      if (wr_en && addr == 8'h10) m_ld_hi <= wdata;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00:   return {16'h0, m_div, 8'h00};
      8'h04:   return m_cnt[31:0];
      8'h08:   return m_cnt[63:32];
      8'h0C:   return m_ld_lo;
      8'h10:   return m_ld_hi;
      8'h14:   return m_snap[31:0];
      8'h18:   return m_snap[63:32];
      default: return 32'h0;
    endcase
  endfunction

  typedef struct { logic [7:0] a; logic [31:0] e; string tag; } item_t;
  item_t sb[$];

  // monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.e) begin
        fails++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    it.a = a; it.e = exp_rd(a); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; addr = 8'h40;
    end
  endtask

  task automatic preload(input logic [63:0] v, input logic [7:0] dv);
    wr(8'h0C, v[31:0]);
    wr(8'h10, v[63:32]);
    wr(8'h00, {16'h0, dv, 8'h03});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1");
    rd(8'h14, "R1"); rd(8'h18, "R1"); rd(8'h08, "R1");
    // R2 R10 full-rate counting, unmapped reads zero
    rd(8'h04, "R2"); rd(8'h04, "R2"); rd(8'h04, "R2");
    rd(8'h1C, "R10"); rd(8'h20, "R10");
    // R4 snapshot, R5 hold while running
    idle(5);
    wr(8'h00, 32'h0000_0001);
    rd(8'h14, "R4"); rd(8'h18, "R4");
    idle(20);
    rd(8'h14, "R5"); rd(8'h04, "R5");
    // R6 load and read back next clock
    preload(64'h0123_4567_89AB_CDEF, 8'h00);
    rd(8'h04, "R6"); rd(8'h08, "R6"); rd(8'h0C, "R6"); rd(8'h10, "R6");
    // R2 carry into high word
    preload(64'h0000_0000_FFFF_FFFE, 8'h00);
    rd(8'h08, "R2"); rd(8'h08, "R2"); rd(8'h04, "R2"); rd(8'h08, "R2");
    // R7 wrap through all ones
    preload(64'hFFFF_FFFF_FFFF_FFFD, 8'h00);
    rd(8'h04, "R7"); rd(8'h08, "R7"); rd(8'h08, "R7"); rd(8'h04, "R7");
    wr(8'h00, 32'h0000_0001);
    rd(8'h14, "R7"); rd(8'h18, "R7");
    // R3 divider 3, then load with restart under divider
    wr(8'h00, 32'h0000_0300);
    for (int i = 0; i < 12; i++) rd(8'h04, "R3");
    preload(64'h0000_0000_0000_0064, 8'h03);
    for (int i = 0; i < 10; i++) rd(8'h04, "R3");
    // R8 control readback with command bits clear
    rd(8'h00, "R8");
    wr(8'h00, 32'h0000_0301);
    rd(8'h00, "R8"); rd(8'h14, "R8");
    // R9 writes that must not act
    wr(8'h04, 32'hDEAD_BEEF);
    wr(8'h18, 32'hCAFE_F00D);
    wr(8'h00, 32'h0000_0002);
    rd(8'h14, "R9"); rd(8'h18, "R9"); rd(8'h04, "R9"); rd(8'h08, "R9");
    // R3 large divider
    wr(8'h00, 32'h0000_FF00);
    for (int i = 0; i < 6; i++) begin idle(60); rd(8'h04, "R3"); end
    rd(8'h00, "R8");
    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule